// File: doc/BRIEF.md
# Clock Mode Decoder with Test-Divide Chain

This block turns four board-level select pins into the operating mode of a system clock generator's output stage. The pins are a speed select, a two-bit mode select and an active-low spread enable. The block's single clock input is either the internal VCO, for run modes, or an external test clock forced onto the crystal input, for test mode. One synchronous counter produces every derived clock from that input. Run modes use two ratio sets, one for each speed. Test mode uses a fixed power-of-two tree. The block also drives a per-group output-enable vector, a flag that tells the pad ring to float the 48 MHz pin rather than drive it low, and a two-bit code for the external spread-spectrum modulator.

In fast speed the VCO runs at twice the CPU rate. In slow speed it runs at four times the CPU rate. The fixed 66 MHz group divides an internal half-VCO node by two in fast speed and by three in slow speed. The bus group runs at half the 66 MHz group, and the APIC group lands at 16.67 MHz in both speeds. The reference and 48 MHz outputs come from the crystal oscillator and the USB synthesiser in run modes, and from the test tree in test mode. The select pins pass through a synchroniser. Any change of mode restarts the counter so that the first period after the change is whole.

Top module: `clkmode_gen`

## Requirements
- R1: With sel_mode = 00 and sel_fast = 0, grp_oe is all zero, spread_code is 00, and every divided clock, ref_clk and usb_clk is held low.
- R2: With sel_mode = 00 and sel_fast = 1 (test), counting k from 0 in the first cycle after the mode takes effect, each output equals floor(k/h) mod 2. The half-period h is 1 for cpu_clk and usb_clk, 2 for half_clk and f66_clk, 4 for bus_clk and 8 for apic_clk.
- R3: In test, ref_clk follows the clk input level directly, and every grp_oe bit is 1.
- R4: With sel_fast = 1 and sel_mode ≠ 00 (fast run), the divided clocks use the same half-periods as R2.
- R5: With sel_fast = 0 and sel_mode ≠ 00 (slow run), the half-periods are 2 for cpu_clk, 4 for half_clk, 3 for f66_clk, 6 for bus_clk and 12 for apic_clk.
- R6: In both run speeds half_clk has exactly twice the period of cpu_clk and rises only while cpu_clk is low.
- R7: sel_mode = 10 sets usb_hold_z to 1, clears grp_oe bit 6 (usb) and keeps bits 0 to 5 at 1. Bit order is 0 cpu, 1 half, 2 f66, 3 bus, 4 apic, 5 ref, 6 usb. Any other setting gives usb_hold_z = 0.
- R8: spread_code is 00 (off) when spread_n = 1 or sel_mode = 00. With spread_n = 0 it is 01 (center) for sel_mode = 01 and 10 (down) for sel_mode = 1x. Code 11 is never driven.
- R9: A change of mode (hi-Z, test, slow run or fast run) drives every divided clock low in its first cycle and restarts all ratios from k = 0.
- R10: Select pins act after SYNC_STAGES + 1 rising clk edges. Before that the previous mode stays on the outputs.
- R11: While rst_n is low, grp_oe, spread_code, usb_hold_z and all clocks are 0.
- R12: In run modes ref_clk equals ref_src, and usb_clk equals usb_src unless usb_hold_z is set, in which case it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock in run modes, test clock in test mode |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_fast | input | 1 | Speed select, 1 = 133 MHz class |
| sel_mode | input | 2 | Mode select pins |
| spread_n | input | 1 | Active-low spread enable |
| ref_src | input | 1 | Crystal oscillator output for run modes |
| usb_src | input | 1 | 48 MHz synthesiser output for run modes |
| cpu_clk | output | 1 | CPU group clock |
| half_clk | output | 1 | Half-rate CPU group clock |
| f66_clk | output | 1 | Fixed 66 MHz group clock |
| bus_clk | output | 1 | Bus group clock |
| apic_clk | output | 1 | APIC group clock |
| ref_clk | output | 1 | Reference group clock |
| usb_clk | output | 1 | 48 MHz group clock |
| grp_oe | output | 7 | Per-group output enable |
| usb_hold_z | output | 1 | Float the 48 MHz pin instead of driving low |
| spread_code | output | 2 | Modulator code |

## Verification
Two events can land in the same cycle: the restart forced by a mode change, and the counter's own wrap or mid-period toggles of every group. Successive runs alternate between modes of different ratio sets and have lengths that are not multiples of the counter period, so each change arrives with the old counter part-way through its cycle. The scoreboard expects all groups low in the first cycle after the change. It also expects each group's first rise after exactly its new half-period, whatever state the old count had reached.

// File: rtl/clkmode_pkg.sv
`timescale 1ns/1ps
// Shared types and ratio constants for the clock mode decoder.
// Assumes five divided groups in the order cpu, half, f66, bus, apic.
package clkmode_pkg;

    typedef enum logic [1:0] {
        MD_HIZ  = 2'd0,
        MD_TEST = 2'd1,
        MD_SLOW = 2'd2,
        MD_FAST = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SP_OFF    = 2'd0,
        SP_CENTER = 2'd1,
        SP_DOWN   = 2'd2,
        SP_RSVD   = 2'd3
    } spread_e;

    localparam int NDIV     = 5;
    localparam int NGRP     = 7;
    localparam int PER_FAST = 16;
    localparam int PER_SLOW = 24;

    // Half-period in input cycles of divided group g in fast run and test.
    function automatic int hp_fast(input int g);
        case (g)
            0:       return 1;
            1:       return 2;
            2:       return 2;
            3:       return 4;
            default: return 8;
        endcase
    endfunction

    // Half-period in input cycles of divided group g in slow run.
    function automatic int hp_slow(input int g);
        case (g)
            0:       return 2;
            1:       return 4;
            2:       return 3;
            3:       return 6;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/clkmode_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for the asynchronous select pins.
// Assumes the pins are quasi-static; each bit is synchronised on its own.
module clkmode_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage re-samples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/clkmode_decode.sv
`timescale 1ns/1ps
// Combinational select decoder: mode, spread code and 48 MHz float flag.
// Assumes synchronised inputs; reserved spread settings map to off.
module clkmode_decode
    import clkmode_pkg::*;
(
    input  logic       sel_fast,
    input  logic [1:0] sel_mode,
    input  logic       spread_n,
    output mode_e      mode,
    output spread_e    code,
    output logic       usb_z
);

    // Choose the output mode from speed and mode pins.
    always_comb begin
        if (sel_mode == 2'b00) mode = sel_fast ? MD_TEST : MD_HIZ;
        else                   mode = sel_fast ? MD_FAST : MD_SLOW;
    end

    // Choose the modulator code; inactive pin or floating modes give off.
    always_comb begin
        if (spread_n || sel_mode == 2'b00) code = SP_OFF;
        else if (sel_mode == 2'b01)        code = SP_CENTER;
        else                               code = SP_DOWN;
    end

    // The 48 MHz synthesiser is disabled for this one mode setting.
    assign usb_z = (sel_mode == 2'b10);

endmodule

// File: rtl/clkmode_divtree.sv
`timescale 1ns/1ps
// Single synchronous counter feeding all divided groups, so every
// group changes on the same input edge. Assumes PER_F and PER_S are
// multiples of twice each group's half-period for their speed.
module clkmode_divtree
    import clkmode_pkg::*;
#(
    parameter int PER_F = PER_FAST,
    parameter int PER_S = PER_SLOW,
    localparam int PER_MAX = (PER_S > PER_F) ? PER_S : PER_F,
    localparam int CNT_W   = $clog2(PER_MAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic            slow,
    output logic [NDIV-1:0] lvl
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [NDIV-1:0]  lvl_nxt;
    logic             at_end;

    // Detect the last count of the active period.
    assign at_end = slow ? (cnt == CNT_W'(PER_S - 1)) : (cnt == CNT_W'(PER_F - 1));

    // Next count: zero on restart or idle, wrap at period end.
    always_comb begin
        if (restart || !run) cnt_nxt = '0;
        else if (at_end)     cnt_nxt = '0;
        else                 cnt_nxt = cnt + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < NDIV; g++) begin : g_grp
            localparam int HF = hp_fast(g);
            localparam int HS = hp_slow(g);
            // Level is high in the second half of each group period.
            always_comb begin
                if (slow) lvl_nxt[g] = ((int'(cnt_nxt) % (2 * HS)) >= HS);
                else      lvl_nxt[g] = ((int'(cnt_nxt) % (2 * HF)) >= HF);
            end
        end
    endgenerate

    // Register counter and all levels on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lvl <= '0;
        end else begin
            cnt <= cnt_nxt;
            lvl <= lvl_nxt;
        end
    end

endmodule

// File: rtl/clkmode_gen.sv
`timescale 1ns/1ps
// Top: synchronises selects, holds the active mode, drives the divide
// tree, the output enables, the spread code and the 48 MHz float flag.
// Assumes clk is the VCO in run modes and the test clock in test mode.
module clkmode_gen
    import clkmode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_fast,
    input  logic [1:0]  sel_mode,
    input  logic        spread_n,
    input  logic        ref_src,
    input  logic        usb_src,
    output logic        cpu_clk,
    output logic        half_clk,
    output logic        f66_clk,
    output logic        bus_clk,
    output logic        apic_clk,
    output logic        ref_clk,
    output logic        usb_clk,
    output logic [6:0]  grp_oe,
    output logic        usb_hold_z,
    output logic [1:0]  spread_code
);

    localparam int SW = 4;

    logic [SW-1:0]   pins_s;
    mode_e           mode_new;
    mode_e           mode_q;
    spread_e         code_new;
    spread_e         code_q;
    logic            usbz_new;
    logic            usbz_q;
    logic            mode_chg;
    logic            run_en;
    logic [NDIV-1:0] lvl;

    clkmode_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_fast, sel_mode, spread_n}),
        .q     (pins_s)
    );

    clkmode_decode u_dec (
        .sel_fast (pins_s[3]),
        .sel_mode (pins_s[2:1]),
        .spread_n (pins_s[0]),
        .mode     (mode_new),
        .code     (code_new),
        .usb_z    (usbz_new)
    );

    assign mode_chg = (mode_new != mode_q);
    assign run_en   = (mode_q != MD_HIZ);

    // Hold the decoded mode, spread code and float flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_HIZ;
            code_q <= SP_OFF;
            usbz_q <= 1'b0;
        end else begin
            mode_q <= mode_new;
            code_q <= code_new;
            usbz_q <= usbz_new;
        end
    end

    clkmode_divtree u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (mode_chg),
        .run     (run_en),
        .slow    (mode_q == MD_SLOW),
        .lvl     (lvl)
    );

    assign cpu_clk  = lvl[0];
    assign half_clk = lvl[1];
    assign f66_clk  = lvl[2];
    assign bus_clk  = lvl[3];
    assign apic_clk = lvl[4];

    // Select the reference source: test clock itself or the oscillator.
    always_comb begin
        if (mode_q == MD_TEST) ref_clk = clk;
        else if (run_en)       ref_clk = ref_src;
        else                   ref_clk = 1'b0;
    end

    // Select the 48 MHz source: test tree, synthesiser or held low.
    always_comb begin
        if (mode_q == MD_TEST)     usb_clk = lvl[0];
        else if (run_en && !usbz_q) usb_clk = usb_src;
        else                       usb_clk = 1'b0;
    end

    // Enable every group unless floating; drop only usb when it floats.
    always_comb begin
        if (!run_en)     grp_oe = 7'b0000000;
        else if (usbz_q) grp_oe = 7'b0111111;
        else             grp_oe = 7'b1111111;
    end

    assign usb_hold_z  = usbz_q;
    assign spread_code = code_q;

endmodule

// File: rtl/clkmode_chk.sv
`timescale 1ns/1ps
// Property checker for clkmode_gen, attached by bind below.
module clkmode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_clk,
    input logic       half_clk,
    input logic       bus_clk,
    input logic       apic_clk,
    input logic       usb_clk,
    input logic       f66_clk,
    input logic [6:0] grp_oe,
    input logic       usb_hold_z,
    input logic [1:0] spread_code,
    input logic       mode_chg
);

    logic chg_d;

    // Remember a mode change one cycle so the forced-low step is skipped.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_d <= 1'b1;
        else        chg_d <= mode_chg;
    end

    a_r1_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_oe == 7'b0) |-> ({cpu_clk, half_clk, f66_clk, bus_clk, apic_clk, usb_clk} == 6'b0));

    a_r7_usb_float: assert property (@(posedge clk) disable iff (!rst_n)
        usb_hold_z |-> (grp_oe == 7'b0111111));

    a_r6_half_rise_cpu_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_clk) |-> !cpu_clk);

    a_r6_half_moves_with_cpu: assert property (@(posedge clk) disable iff (!rst_n || chg_d)
        !$stable(half_clk) |-> !$stable(cpu_clk));

    a_r2_apic_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(apic_clk) |-> (!cpu_clk && !bus_clk));

    a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        spread_code != 2'b11);

    a_r8_center_not_float: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_code == 2'b01) |-> !usb_hold_z);

endmodule

bind clkmode_gen clkmode_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_clk     (cpu_clk),
    .half_clk    (half_clk),
    .bus_clk     (bus_clk),
    .apic_clk    (apic_clk),
    .usb_clk     (usb_clk),
    .f66_clk     (f66_clk),
    .grp_oe      (grp_oe),
    .usb_hold_z  (usb_hold_z),
    .spread_code (spread_code),
    .mode_chg    (mode_chg)
);

// File: tb/clkmode_gen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expected per-cycle items, monitor compares.
module clkmode_gen_tb;

    typedef struct {
        logic [4:0] dv;     // {apic, bus, f66, half, cpu}
        logic       ref_hi;
        logic       ref_lo;
        logic       usb;
        logic [6:0] oe;
        logic [1:0] code;
        logic       hz;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_fast = 1'b0;
    logic [1:0] sel_mode = 2'b00;
    logic       spread_n = 1'b1;
    logic       ref_src = 1'b0;
    logic       usb_src = 1'b0;
    logic       cpu_clk, half_clk, f66_clk, bus_clk, apic_clk, ref_clk, usb_clk;
    logic [6:0] grp_oe;
    logic       usb_hold_z;
    logic [1:0] spread_code;

    exp_t q[$];
    int   nvec = 0;
    int   nfail = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    clkmode_gen u_dut (
        .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast), .sel_mode(sel_mode),
        .spread_n(spread_n), .ref_src(ref_src), .usb_src(usb_src),
        .cpu_clk(cpu_clk), .half_clk(half_clk), .f66_clk(f66_clk),
        .bus_clk(bus_clk), .apic_clk(apic_clk), .ref_clk(ref_clk),
        .usb_clk(usb_clk), .grp_oe(grp_oe), .usb_hold_z(usb_hold_z),
        .spread_code(spread_code)
    );

    // Build one expected item; md: 0 hi-Z, 1 test, 2 slow, 3 fast.
    function automatic exp_t mk(input int md, input int k, input bit hold,
                                input logic [1:0] code, input bit rs,
                                input bit us, input string req);
        exp_t e;
        int hf[5] = '{1, 2, 2, 4, 8};
        int hs[5] = '{2, 4, 3, 6, 12};
        e.req = req;
        e.code = code;
        e.hz = hold;
        for (int g = 0; g < 5; g++)
            e.dv[g] = (md == 0) ? 1'b0 : (((k / ((md == 2) ? hs[g] : hf[g])) % 2) == 1);
        if (md == 0) begin
            e.ref_hi = 0; e.ref_lo = 0; e.usb = 0; e.oe = 7'h00;
        end else if (md == 1) begin
            e.ref_hi = 1; e.ref_lo = 0; e.usb = ((k % 2) == 1); e.oe = 7'h7F;
        end else begin
            e.ref_hi = rs; e.ref_lo = rs; e.usb = hold ? 1'b0 : us;
            e.oe = hold ? 7'h3F : 7'h7F;
        end
        return e;
    endfunction

    // Driver: apply pins, wait out sync latency, push expected items.
    task automatic run(input bit fast, input logic [1:0] m, input bit spn,
                       input bit rs, input bit us, input int n,
                       input string req, input bit lat);
        int md;
        bit hold;
        logic [1:0] code;
        #3;
        sel_fast = fast; sel_mode = m; spread_n = spn; ref_src = rs; usb_src = us;
        md   = (m == 2'b00) ? (fast ? 1 : 0) : (fast ? 3 : 2);
        hold = (m == 2'b10);
        code = (spn || m == 2'b00) ? 2'b00 : ((m == 2'b01) ? 2'b01 : 2'b10);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            // R10: old hi-Z state must persist for the first two edges
            if (lat && i < 2) q.push_back(mk(0, 0, 0, 2'b00, 0, 0, req));
        end
        for (int k = 0; k < n; k++) begin
            q.push_back(mk(md, k, hold, code, rs, us, req));
            @(posedge clk);
        end
    endtask

    // Monitor: compare one expected item per cycle, ref level also mid-low.
    initial begin
        exp_t e;
        bit bad;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                bad = 0;
                if ({apic_clk, bus_clk, f66_clk, half_clk, cpu_clk} !== e.dv ||
                    ref_clk !== e.ref_hi || usb_clk !== e.usb || grp_oe !== e.oe ||
                    spread_code !== e.code || usb_hold_z !== e.hz) begin
                    bad = 1;
                    $display("FAIL %s div=%b/%b ref=%b/%b usb=%b/%b oe=%b/%b code=%b/%b hz=%b/%b (act/exp)",
                             e.req, {apic_clk, bus_clk, f66_clk, half_clk, cpu_clk}, e.dv,
                             ref_clk, e.ref_hi, usb_clk, e.usb, grp_oe, e.oe,
                             spread_code, e.code, usb_hold_z, e.hz);
                end
                #5;
                if (ref_clk !== e.ref_lo) begin
                    bad = 1;
                    $display("FAIL %s ref_clk low phase act=%b exp=%b", e.req, ref_clk, e.ref_lo);
                end
                nvec++;
                if (bad) nfail++;
            end
        end
    end

    // Stimulus sequence; consecutive runs always differ in mode (R9).
    initial begin
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            q.push_back(mk(0, 0, 0, 2'b00, 0, 0, "R11"));   // reset state
        end
        #3 rst_n = 1'b1;
        @(posedge clk);
        run(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 40, "R2 R3 test", 1'b0);
        run(1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 40, "R4 R8 R12 fast", 1'b0);
        run(1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 61, "R5 R6 R9 slow", 1'b0);
        run(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 21, "R8 R9 center", 1'b0);
        run(1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 30, "R7 R8 float", 1'b0);
        run(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 10, "R1 hiz", 1'b0);
        run(1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 20, "R10 latency", 1'b1);
        repeat (3) @(posedge clk);
        #9;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule